// File: doc/BRIEF.md
# Two-Port Shared Mailbox Memory with Address-Contention Arbiter

This block is a small shared memory that two independent agents use to pass data to each other. Each side has its own address, active-low select, write strobe and output strobe. Each side also has its own write-data and read-data buses, a read-data drive flag in place of three-state pins, and an active-low not-ready flag. Either side can treat the block as a plain RAM. Both sides can work at the same time as long as they touch different words.

When both sides are selected and present the same address, an arbiter steps in. The side that was already sitting at that address keeps access. The late side sees its not-ready flag go low. Its writes are dropped and its read data is not driven until the addresses differ again, and then its access goes ahead without any retry protocol. If both sides arrive in the same cycle, side A wins. The grant is held in a register for as long as the match lasts.

The block is modelled on a single clock. All port inputs are sampled on the rising edge. Read data and the drive flag are registered. The not-ready flags follow the current inputs combinationally, so an agent sees its stall in the same cycle it presents the conflicting address.

Top module: `mbx_dual_port`

## Requirements
- R1: With select low, write strobe low and not-ready high, the write data is stored at the port's address on that clock edge.
- R2: With select low, output strobe low, write strobe high and not-ready high, the next cycle shows the stored word on the read-data bus with the drive flag at 1.
- R3: While in reset, or in any cycle after a cycle where select or output strobe was high, the drive flag is 0. A write strobe with select high stores nothing.
- R4: Contention exists only when both selects are low and both addresses are equal. At all other times both not-ready flags are high.
- R5: During contention exactly one not-ready flag is low.
- R6: The port that was selected at the same address in the previous cycle keeps access. The newly arriving port gets not-ready low.
- R7: A write made while that port's not-ready is low leaves memory unchanged.
- R8: The winner chosen when contention starts stays the winner for every cycle the match lasts, even if both ports move to a new common address together.
- R9: When the match ends, the stalled port's not-ready returns high in that same cycle, and the access it presents proceeds.
- R10: When both ports enter the match in the same cycle, port A is granted and port B gets not-ready low.
- R11: A read made while that port's not-ready is low gives drive flag 0 in the next cycle.
- R12: A stored word is returned by a read from either port in any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_cs_n | input | 1 | Port A select, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output strobe, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, registered |
| a_rdata_oe | output | 1 | Port A read data drive flag |
| a_nrdy_n | output | 1 | Port A not-ready, low while stalled |
| b_cs_n | input | 1 | Port B select, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output strobe, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, registered |
| b_rdata_oe | output | 1 | Port B read data drive flag |
| b_nrdy_n | output | 1 | Port B not-ready, low while stalled |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, 8-bit words and 256 locations. This lets it preload every word once and then compare all later reads against a full shadow copy. The random phase keeps both ports within the lowest four addresses, so matches, arrivals by one side, same-cycle ties and joint moves happen often rather than rarely. Directed sequences force each kind of contention start and release at chosen data values, so that a dropped write shows up in a later readback.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NPORT  = 2;
  localparam int PORT_A = 0;
  localparam int PORT_B = 1;

  typedef enum logic {
    OWNER_A = 1'b0,
    OWNER_B = 1'b1
  } owner_e;
endpackage

// File: rtl/mbx_port_ctl.sv
module mbx_port_ctl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              stall,
  output logic              sel,
  output logic              early,
  output logic              wr_go,
  output logic              rd_go
);
  logic              prev_sel_q, prev_sel_d;
  logic [ADDR_W-1:0] prev_addr_q, prev_addr_d;

  // mode decode
  always_comb begin
    sel   = ~cs_n;
    wr_go = sel & ~we_n & ~stall;
    rd_go = sel & we_n & ~oe_n & ~stall;
    early = prev_sel_q & (prev_addr_q == addr);
  end

  // next state of the presence tracker
  always_comb begin
    prev_sel_d  = sel;
    prev_addr_d = prev_addr_q;
    if (sel) prev_addr_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel_q  <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_sel_q  <= prev_sel_d;
      prev_addr_q <= prev_addr_d;
    end
  end

  // R7: a stalled port never issues a write
  p_stalled_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !wr_go);
  // R3: a deselected port issues neither a read nor a write
  p_deselect_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!wr_go && !rd_go));
endmodule

// File: rtl/mbx_arbiter.sv
module mbx_arbiter
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              early_a,
  input  logic              early_b,
  output logic              stall_a,
  output logic              stall_b
);
  logic   match;
  logic   hold_q, hold_d;
  owner_e owner_q, owner_d;
  owner_e fresh, winner;

  always_comb begin
    match   = sel_a & sel_b & (addr_a == addr_b);
    // a port that was already parked here wins; a tie goes to A
    fresh   = (early_b && !early_a) ? OWNER_B : OWNER_A;
    winner  = hold_q ? owner_q : fresh;
    stall_a = match & (winner == OWNER_B);
    stall_b = match & (winner == OWNER_A);
  end

  always_comb begin
    hold_d  = match;
    owner_d = owner_q;
    if (match) owner_d = winner;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      owner_q <= OWNER_A;
    end else begin
      hold_q  <= hold_d;
      owner_q <= owner_d;
    end
  end

  // R5: exactly one loser during contention
  p_one_loser_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (stall_a != stall_b));
  // R4: no stall without a match
  p_no_spurious_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !match |-> (!stall_a && !stall_b));
  // R8: the grant does not flip while a match persists
  p_grant_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match && hold_q) |-> ($stable(stall_a) && $stable(stall_b)));
endmodule

// File: rtl/mbx_store.sv
module mbx_store
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              wr_go,
  input  logic [NPORT-1:0]              rd_go,
  input  logic [NPORT-1:0][ADDR_W-1:0]  addr,
  input  logic [NPORT-1:0][DATA_W-1:0]  wdata,
  output logic [NPORT-1:0][DATA_W-1:0]  rdata,
  output logic [NPORT-1:0]              rdata_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // storage array, no reset
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      if (wr_go[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    logic [DATA_W-1:0] dq, dd;
    logic              eq, ed;

    always_comb begin
      ed = rd_go[p];
      dd = dq;
      if (rd_go[p]) dd = mem[addr[p]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dq <= '0;
        eq <= 1'b0;
      end else begin
        dq <= dd;
        eq <= ed;
      end
    end

    assign rdata[p]    = dq;
    assign rdata_oe[p] = eq;

    // R2: an accepted read drives its data the next cycle
    p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go[p] |=> rdata_oe[p]);
    // R11 / R3: no accepted read, no drive next cycle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go[p] |=> !rdata_oe[p]);
  end

  // R7: the arbiter never lets both ports write one word together
  p_single_writer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go[PORT_A] && wr_go[PORT_B]) |-> (addr[PORT_A] != addr[PORT_B]));
endmodule

// File: rtl/mbx_dual_port.sv
module mbx_dual_port
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_cs_n,
  input  logic              a_we_n,
  input  logic              a_oe_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rdata_oe,
  output logic              a_nrdy_n,
  input  logic              b_cs_n,
  input  logic              b_we_n,
  input  logic              b_oe_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rdata_oe,
  output logic              b_nrdy_n
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  // reset asserts at once, releases after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [NPORT-1:0]             cs_n_v, we_n_v, oe_n_v;
  logic [NPORT-1:0][ADDR_W-1:0] addr_v;
  logic [NPORT-1:0][DATA_W-1:0] wdata_v, rdata_v;
  logic [NPORT-1:0]             sel_v, early_v, stall_v, wr_go_v, rd_go_v, oe_v;

  assign cs_n_v  = {b_cs_n, a_cs_n};
  assign we_n_v  = {b_we_n, a_we_n};
  assign oe_n_v  = {b_oe_n, a_oe_n};
  assign addr_v  = {b_addr, a_addr};
  assign wdata_v = {b_wdata, a_wdata};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbx_port_ctl #(.ADDR_W(ADDR_W)) u_ctl (
      .clk   (clk),
      .rst_n (rst_int_n),
      .cs_n  (cs_n_v[p]),
      .we_n  (we_n_v[p]),
      .oe_n  (oe_n_v[p]),
      .addr  (addr_v[p]),
      .stall (stall_v[p]),
      .sel   (sel_v[p]),
      .early (early_v[p]),
      .wr_go (wr_go_v[p]),
      .rd_go (rd_go_v[p])
    );
  end

  mbx_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sel_a   (sel_v[PORT_A]),
    .sel_b   (sel_v[PORT_B]),
    .addr_a  (addr_v[PORT_A]),
    .addr_b  (addr_v[PORT_B]),
    .early_a (early_v[PORT_A]),
    .early_b (early_v[PORT_B]),
    .stall_a (stall_v[PORT_A]),
    .stall_b (stall_v[PORT_B])
  );

  mbx_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_go    (wr_go_v),
    .rd_go    (rd_go_v),
    .addr     (addr_v),
    .wdata    (wdata_v),
    .rdata    (rdata_v),
    .rdata_oe (oe_v)
  );

  assign a_rdata    = rdata_v[PORT_A];
  assign b_rdata    = rdata_v[PORT_B];
  assign a_rdata_oe = oe_v[PORT_A];
  assign b_rdata_oe = oe_v[PORT_B];
  assign a_nrdy_n   = ~stall_v[PORT_A];
  assign b_nrdy_n   = ~stall_v[PORT_B];

  // R4: differing addresses or an idle side means both ports ready
  p_ready_without_match_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (a_cs_n || b_cs_n || (a_addr != b_addr)) |-> (a_nrdy_n && b_nrdy_n));
  // R5: at a live match one flag is low
  p_match_flags_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!a_cs_n && !b_cs_n && (a_addr == b_addr)) |-> $countones({a_nrdy_n, b_nrdy_n}) == 1);
  // R11: a stalled port does not drive read data next cycle
  p_stalled_undriven_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !b_nrdy_n |=> !b_rdata_oe);
endmodule

// File: tb/mbx_dual_port_tb.sv
`timescale 1ns/1ps
module mbx_dual_port_tb;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic a_cs_n, a_we_n, a_oe_n, b_cs_n, b_we_n, b_oe_n;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_rdata_oe, b_rdata_oe, a_nrdy_n, b_nrdy_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mbx_dual_port #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rdata_oe(a_rdata_oe), .a_nrdy_n(a_nrdy_n),
    .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rdata_oe(b_rdata_oe), .b_nrdy_n(b_nrdy_n)
  );

  // shadow state built from the requirements
  logic [DW-1:0] sh_mem [256];
  logic          sh_psel_a, sh_psel_b, sh_hold, sh_owner_b;
  logic [AW-1:0] sh_paddr_a, sh_paddr_b;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic win_b_of(logic ca, logic cb, logic [AW-1:0] aa, logic [AW-1:0] ab);
    logic ea, eb;
    ea = sh_psel_a && (sh_paddr_a == aa);
    eb = sh_psel_b && (sh_paddr_b == ab);
    if (sh_hold) return sh_owner_b;
    return eb && !ea;
  endfunction

  // one clock: drive at negedge, check flags, then check registered reads
  task automatic cyc(string tag,
                     logic ac, logic aw, logic ao, logic [AW-1:0] aa, logic [DW-1:0] ad,
                     logic bc, logic bw, logic bo, logic [AW-1:0] ba, logic [DW-1:0] bd);
    logic match, wb, na, nb, ra, rb;
    logic [DW-1:0] xa, xb;
    a_cs_n = ac; a_we_n = aw; a_oe_n = ao; a_addr = aa; a_wdata = ad;
    b_cs_n = bc; b_we_n = bw; b_oe_n = bo; b_addr = ba; b_wdata = bd;
    #1;
    match = !ac && !bc && (aa == ba);
    wb    = win_b_of(ac, bc, aa, ba);
    na    = !(match && wb);
    nb    = !(match && !wb);
    chk(tag, "a_nrdy_n", a_nrdy_n, na);
    chk(tag, "b_nrdy_n", b_nrdy_n, nb);
    ra = !ac && aw && !ao && na;
    rb = !bc && bw && !bo && nb;
    xa = sh_mem[aa];
    xb = sh_mem[ba];
    if (!ac && !aw && na) sh_mem[aa] = ad;
    if (!bc && !bw && nb) sh_mem[ba] = bd;
    sh_hold = match;
    if (match) sh_owner_b = wb;
    sh_psel_a = !ac; if (!ac) sh_paddr_a = aa;
    sh_psel_b = !bc; if (!bc) sh_paddr_b = ba;
    @(posedge clk); #1;
    chk(tag, "a_rdata_oe", a_rdata_oe, ra);
    chk(tag, "b_rdata_oe", b_rdata_oe, rb);
    if (ra) chk(tag, "a_rdata", a_rdata, xa);
    if (rb) chk(tag, "b_rdata", b_rdata, xb);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc("R4", 1, 1, 1, 0, 0, 1, 1, 1, 0, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    sh_psel_a = 0; sh_psel_b = 0; sh_hold = 0; sh_owner_b = 0;
    sh_paddr_a = '0; sh_paddr_b = '0;
    rst_n = 1'b0;
    a_cs_n = 1; a_we_n = 1; a_oe_n = 1; a_addr = 0; a_wdata = 0;
    b_cs_n = 1; b_we_n = 1; b_oe_n = 1; b_addr = 0; b_wdata = 0;
    repeat (4) @(negedge clk);
    // R3: reset state, nothing driven, both ready
    chk("R3", "a_rdata_oe", a_rdata_oe, 0);
    chk("R3", "b_rdata_oe", b_rdata_oe, 0);
    chk("R4", "a_nrdy_n", a_nrdy_n, 1);
    chk("R4", "b_nrdy_n", b_nrdy_n, 1);
    rst_n = 1'b1;
    idle(4);

    // R1: fill every word from port A
    for (int i = 0; i < 256; i++) cyc("R1", 0, 0, 1, i[7:0], i[7:0] ^ 8'h5A, 1, 1, 1, 0, 0);
    // R2: read samples from port B, R12 values seen from the other side
    for (int i = 0; i < 16; i++) cyc("R2", 1, 1, 1, 0, 0, 0, 1, 0, i[7:0] * 8'd16 + 8'd3, 0);
    cyc("R12", 1, 1, 1, 0, 0, 0, 1, 0, 8'd255, 0);

    // R3: output strobe high means no drive; select high blocks a write
    cyc("R3", 1, 0, 0, 8'd7, 8'hEE, 0, 1, 1, 8'd7, 0);
    cyc("R3", 1, 1, 1, 0, 0, 0, 1, 0, 8'd7, 0);

    // R4: both writing, different words, no stall
    cyc("R4", 0, 0, 1, 8'd100, 8'hA1, 0, 0, 1, 8'd101, 8'hB1);
    cyc("R4", 0, 1, 0, 8'd101, 0, 0, 1, 0, 8'd100, 0);

    // R6: A parked at 10, B arrives with a write
    cyc("R6", 0, 1, 0, 8'd10, 0, 1, 1, 1, 0, 0);
    cyc("R6", 0, 1, 0, 8'd10, 0, 0, 0, 1, 8'd10, 8'h77);
    cyc("R7", 0, 1, 0, 8'd10, 0, 0, 0, 1, 8'd10, 8'h77);
    // R9: A leaves, B released and writes
    cyc("R9", 0, 1, 0, 8'd11, 0, 0, 0, 1, 8'd10, 8'h77);
    cyc("R12", 0, 1, 0, 8'd10, 0, 1, 1, 1, 0, 0);

    // R6 reversed: B parked at 20, A arrives with a read
    cyc("R6", 1, 1, 1, 0, 0, 0, 1, 0, 8'd20, 0);
    cyc("R11", 0, 1, 0, 8'd20, 0, 0, 1, 0, 8'd20, 0);
    cyc("R9", 0, 1, 0, 8'd20, 0, 1, 1, 1, 0, 0);

    // R10: both arrive together at 30, both writing
    idle(1);
    cyc("R10", 0, 0, 1, 8'd30, 8'hC3, 0, 0, 1, 8'd30, 8'h3C);
    cyc("R10", 1, 1, 1, 0, 0, 0, 1, 0, 8'd30, 0);

    // R8: tie at 40, then both move to 41 together
    idle(1);
    cyc("R8", 0, 1, 0, 8'd40, 0, 0, 1, 0, 8'd40, 0);
    cyc("R8", 0, 1, 0, 8'd41, 0, 0, 0, 1, 8'd41, 8'h99);
    // R8: B owns 50, both move to 51
    idle(1);
    cyc("R8", 1, 1, 1, 0, 0, 0, 1, 0, 8'd50, 0);
    cyc("R8", 0, 0, 1, 8'd50, 8'h12, 0, 1, 0, 8'd50, 0);
    cyc("R8", 0, 0, 1, 8'd51, 8'h34, 0, 1, 0, 8'd51, 0);
    cyc("R7", 0, 1, 0, 8'd51, 0, 1, 1, 1, 0, 0);

    // R5: random traffic over a narrow address window
    for (int i = 0; i < 4000; i++) begin
      cyc("R5",
          ($urandom % 4) == 0, $urandom % 2, $urandom % 2, 8'($urandom % 4), 8'($urandom),
          ($urandom % 4) == 0, $urandom % 2, $urandom % 2, 8'($urandom % 4), 8'($urandom));
    end
    for (int i = 0; i < 4; i++) cyc("R12", 0, 1, 0, i[7:0], 0, 1, 1, 1, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule